// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block turns a single register write into the pin-level start of a NAND flash operation. The write's address offset carries a packed command word: first opcode, optional second opcode, address cycle count, chip select, data-enable and direction flags. The write's 32-bit data carries up to four address bytes. The sequencer drives one command latch cycle, then zero to five address latch cycles, then the second opcode if it is flagged valid. Every cycle is framed by a write-enable low pulse and a high gap. Each of these lasts a fixed number of clocks.

A small register file sits beside the sequencer. It holds an enable state, the edge polarity, a spare address byte that is used as the first of five address bytes, and an interrupt mask. It also holds sticky event bits for command completion and for edges seen on the synchronized ready/busy line. The interrupt line is raised when any event bit is set and also unmasked. Reading the status register clears the event bits.

Top module: `nand_cmd_seq`

## Requirements
- R1: An issue write accepted while enabled and idle makes the sequencer busy from the next clock. While busy, bit 27 of `cmd_rdata` and status bit 8 read 1. Status bit 11 shows the latched direction flag and status bits 14:12 show the latched chip-select id.
- R2: The command word (write offset) has this layout: first opcode in 9:2, second opcode in 17:10, second-opcode-valid in 18, address count in 21:19, chip-select id in 24:22, data-enable in 25, direction in 26. The pins carry the first opcode with CLE high, then the address bytes with ALE high, then the second opcode with CLE high, but only when bit 18 is 1.
- R3: With a count of 5, the spare byte (register 6, bits 7:0) is sent first, followed by write-data bytes 0 to 3. With a count of 1 to 4, that many write-data bytes are sent, least significant first. Counts 6 and 7 behave as 5.
- R4: Each WE# low pulse lasts PULSE_CLKS clocks and each gap between cycles lasts GAP_CLKS clocks. The I/O byte, CLE and ALE are unchanged across every WE# rising edge. CLE and ALE are never high together.
- R5: While busy, exactly one CE# line is low: the one whose index is the chip-select id. When idle, all CE# lines are high.
- R6: An issue write that arrives while busy is ignored. The sequence in progress completes exactly as issued.
- R7: Control register 1 enables the block with bit 0 and disables it with bit 1; disable wins if both are set. An issue write while disabled starts nothing.
- R8: At the end of each sequence, status bit 17 (command done) is set. Status bit 16 (transfer done) is set as well if the data-enable flag was 1.
- R9: After a two-stage synchronizer, a rising edge on R/B# sets status bit 4 and a falling edge sets bit 5. Bit 24 is set on the edge chosen by config bit 12 (0 selects rising, 1 selects falling).
- R10: A read of the status register (register 2) clears event bits 4, 5, 16, 17 and 24. An event arriving in the same cycle as the read stays set, and each event sets again when it next occurs.
- R11: `irq` is the OR of the event bits ANDed with the mask. Writing register 3 sets mask bits, writing register 4 clears them, and register 5 reads the mask back.
- R12: After reset: WE# is high, CLE and ALE are low, all CE# lines are high, I/O is 0, `irq` is 0, and the status, mask and busy readbacks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status events when reading register 2) |
| reg_addr | input | 3 | Register select: 0 config, 1 control, 2 status, 3 mask set, 4 mask clear, 5 mask read, 6 spare address byte |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register |
| cmd_wr | input | 1 | Issue write strobe |
| cmd_ofs | input | 25 | Issue write offset bits 26:2, i.e. the command word |
| cmd_wdata | input | 32 | Issue write data: address bytes 0 to 3 |
| cmd_rdata | output | 32 | Issue region readback; bit 27 is busy |
| irq | output | 1 | Interrupt request |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_ce_n | output | NCS | Chip enables, active low |
| nand_io | output | 8 | I/O byte |
| nand_rb_n | input | 1 | Ready/busy from the flash, asynchronous |

## Verification
The bench records every byte latched on a WE# rising edge and compares the whole list with one built from the command word. This catches a design that swaps the order of the spare byte and the data bytes, drops the second opcode, or mishandles counts 0, 6 and 7. Measured pulse and gap widths show an off-by-one in the timing counters. A check that the bus holds still across each rising edge shows a design that advances the byte too early. An issue write injected mid-sequence exposes a design that reloads its latched command while busy. Separate passes with each R/B# polarity, and reads taken before and after events, show event bits that fail to clear, fail to set again, or follow the wrong edge.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  // command word fields (positions are decoded by software, keep them)
  localparam int CW_W      = 27;
  localparam int OP1_LSB   = 2;
  localparam int OP2_LSB   = 10;
  localparam int V2_BIT    = 18;
  localparam int NAD_LSB   = 19;
  localparam int CS_LSB    = 22;
  localparam int DEN_BIT   = 25;
  localparam int WR_BIT    = 26;
  localparam int BUSY_BIT  = 27;
  localparam int MAX_ADDR  = 5;

  // status bits
  localparam int ST_EN     = 0;
  localparam int ST_RISE   = 4;
  localparam int ST_FALL   = 5;
  localparam int ST_BUSY   = 8;
  localparam int ST_WR     = 11;
  localparam int ST_CS_LSB = 12;
  localparam int ST_XFR    = 16;
  localparam int ST_DONE   = 17;
  localparam int ST_EDGE   = 24;
  localparam int CFG_EDGE  = 12;

  localparam logic [31:0] EVT_BITS = (32'd1 << ST_RISE) | (32'd1 << ST_FALL) |
                                     (32'd1 << ST_XFR)  | (32'd1 << ST_DONE) |
                                     (32'd1 << ST_EDGE);

  typedef enum logic [2:0] {
    RA_CFG   = 3'd0,
    RA_CTRL  = 3'd1,
    RA_STAT  = 3'd2,
    RA_IEN   = 3'd3,
    RA_IDIS  = 3'd4,
    RA_IMASK = 3'd5,
    RA_CYC0  = 3'd6
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  typedef struct packed {
    logic       wr;
    logic       den;
    logic [2:0] cs;
    logic [2:0] nad;
    logic       v2;
    logic [7:0] op2;
    logic [7:0] op1;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [CW_W-1:0] w);
    cmd_t c;
    c.op1 = w[OP1_LSB +: 8];
    c.op2 = w[OP2_LSB +: 8];
    c.v2  = w[V2_BIT];
    c.nad = (w[NAD_LSB +: 3] > 3'(MAX_ADDR)) ? 3'(MAX_ADDR) : w[NAD_LSB +: 3];
    c.cs  = w[CS_LSB +: 3];
    c.den = w[DEN_BIT];
    c.wr  = w[WR_BIT];
    return c;
  endfunction

endpackage

// File: rtl/nand_rb_watch.sv
module nand_rb_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_n_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int LEN = SYNC_STAGES + 1;

  logic [LEN-1:0] sh_q;
  logic [LEN-1:0] sh_n;

  assign sh_n = {sh_q[LEN-2:0], rb_n_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_n;
  end

  assign rise_o =  sh_q[LEN-2] & ~sh_q[LEN-1];
  assign fall_o = ~sh_q[LEN-2] &  sh_q[LEN-1];

  // an edge event is a single-cycle pulse
  assert_rise_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  assert_fall_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/nand_pin_seq.sv
module nand_pin_seq
  import nand_seq_pkg::*;
#(
  parameter int PULSE_CLKS = 2,
  parameter int GAP_CLKS   = 2,
  parameter int NCS        = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  cmd_t            cmd_i,
  input  logic [31:0]     abyte_i,
  input  logic [7:0]      cyc0_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            den_o,
  output logic            wr_o,
  output logic [2:0]      cs_o,
  output logic            we_n_o,
  output logic            cle_o,
  output logic            ale_o,
  output logic [NCS-1:0]  ce_n_o,
  output logic [7:0]      io_o
);
  localparam int CNT_MAX = (PULSE_CLKS > GAP_CLKS) ? PULSE_CLKS : GAP_CLKS;
  localparam int CNTW    = $clog2(CNT_MAX + 1);
  localparam int ABW     = 8 * MAX_ADDR;
  localparam logic [CNTW-1:0] LOW_END  = CNTW'(PULSE_CLKS - 1);
  localparam logic [CNTW-1:0] HIGH_END = CNTW'(GAP_CLKS - 1);

  phase_e          ph_q, ph_n;
  logic [2:0]      step_q, step_n;
  logic [2:0]      last_q, last_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  cmd_t            cmd_q, cmd_n;
  logic [ABW-1:0]  ab_q, ab_n;
  logic            load;
  logic            fin;

  logic            sel_cle, sel_ale;
  logic [7:0]      sel_byte;
  logic            act_n;

  logic            done_q;
  logic            we_n_q, cle_q, ale_q;
  logic [NCS-1:0]  ce_n_q;
  logic [7:0]      io_q;

  // next-state logic
  always_comb begin
    ph_n   = ph_q;
    step_n = step_q;
    last_n = last_q;
    cnt_n  = cnt_q;
    cmd_n  = cmd_q;
    ab_n   = ab_q;
    load   = 1'b0;
    fin    = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (go_i) begin
          load   = 1'b1;
          ph_n   = PH_LOW;
          step_n = '0;
          cnt_n  = '0;
          cmd_n  = cmd_i;
          last_n = cmd_i.nad + {2'b00, cmd_i.v2};
          if (cmd_i.nad == 3'(MAX_ADDR)) ab_n = {abyte_i, cyc0_i};
          else                           ab_n = {8'h00, abyte_i};
        end
      end
      PH_LOW: begin
        if (cnt_q == LOW_END) begin
          ph_n  = PH_HIGH;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PH_HIGH: begin
        if (cnt_q == HIGH_END) begin
          cnt_n = '0;
          if (step_q == last_q) begin
            ph_n = PH_IDLE;
            fin  = 1'b1;
          end else begin
            step_n = step_q + 1'b1;
            ph_n   = PH_LOW;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  // pin decode of the next step
  always_comb begin
    sel_byte = cmd_n.op1;
    sel_cle  = 1'b1;
    sel_ale  = 1'b0;
    if (step_n != 3'd0) begin
      if (step_n <= cmd_n.nad) begin
        sel_byte = ab_n[{step_n - 3'd1, 3'b000} +: 8];
        sel_cle  = 1'b0;
        sel_ale  = 1'b1;
      end else begin
        sel_byte = cmd_n.op2;
      end
    end
  end

  assign act_n = (ph_n != PH_IDLE);

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      step_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      step_q <= step_n;
      cnt_q  <= cnt_n;
      done_q <= fin;
    end
  end

  // latched command, loaded only when a new sequence starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      ab_q   <= '0;
      last_q <= '0;
    end else if (load) begin
      cmd_q  <= cmd_n;
      ab_q   <= ab_n;
      last_q <= last_n;
    end
  end

  // registered pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_n_q <= 1'b1;
      cle_q  <= 1'b0;
      ale_q  <= 1'b0;
      ce_n_q <= '1;
      io_q   <= '0;
    end else begin
      we_n_q <= (ph_n != PH_LOW);
      cle_q  <= act_n & sel_cle;
      ale_q  <= act_n & sel_ale;
      ce_n_q <= act_n ? ~(NCS'(1) << cmd_n.cs) : '1;
      io_q   <= act_n ? sel_byte : 8'h00;
    end
  end

  assign busy_o = (ph_q != PH_IDLE);
  assign done_o = done_q;
  assign den_o  = cmd_q.den;
  assign wr_o   = cmd_q.wr;
  assign cs_o   = cmd_q.cs;
  assign we_n_o = we_n_q;
  assign cle_o  = cle_q;
  assign ale_o  = ale_q;
  assign ce_n_o = ce_n_q;
  assign io_o   = io_q;

  assert_cle_ale_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle_q && ale_q));
  assert_bus_hold_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_q) |-> ($stable(io_q) && $stable(cle_q) && $stable(ale_q)));
  assert_one_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ($countones(~ce_n_q) == 1));
  assert_ce_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> (ce_n_q == '1));
  assert_cmd_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(cmd_q) && $stable(ab_q)));

endmodule

// File: rtl/nand_ctl_regs.sv
module nand_ctl_regs
  import nand_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        busy_i,
  input  logic        wr_i,
  input  logic [2:0]  cs_i,
  input  logic        done_i,
  input  logic        den_i,
  input  logic        rise_i,
  input  logic        fall_i,
  output logic        en_o,
  output logic [7:0]  cyc0_o,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  logic        en_q, en_n;
  logic        edge_q, edge_n;
  logic [7:0]  cyc0_q, cyc0_n;
  logic [31:0] mask_q, mask_n;
  logic [31:0] evt_q, evt_n;
  logic [31:0] set_v;
  logic        rd_clr;
  logic        sel_edge;
  logic [31:0] stat_v;

  assign sel_edge = edge_q ? fall_i : rise_i;
  assign rd_clr   = reg_rd && (reg_addr == RA_STAT);

  always_comb begin
    set_v = '0;
    set_v[ST_RISE] = rise_i;
    set_v[ST_FALL] = fall_i;
    set_v[ST_DONE] = done_i;
    set_v[ST_XFR]  = done_i & den_i;
    set_v[ST_EDGE] = sel_edge;
  end

  always_comb begin
    en_n   = en_q;
    edge_n = edge_q;
    cyc0_n = cyc0_q;
    mask_n = mask_q;
    evt_n  = rd_clr ? set_v : (evt_q | set_v);
    if (reg_wr) begin
      unique case (reg_addr)
        RA_CFG:  edge_n = reg_wdata[CFG_EDGE];
        RA_CTRL: begin
          if (reg_wdata[1])      en_n = 1'b0;
          else if (reg_wdata[0]) en_n = 1'b1;
        end
        RA_IEN:  mask_n = mask_q | (reg_wdata & EVT_BITS);
        RA_IDIS: mask_n = mask_q & ~reg_wdata;
        RA_CYC0: cyc0_n = reg_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      edge_q <= 1'b0;
      cyc0_q <= '0;
      mask_q <= '0;
      evt_q  <= '0;
    end else begin
      en_q   <= en_n;
      edge_q <= edge_n;
      cyc0_q <= cyc0_n;
      mask_q <= mask_n;
      evt_q  <= evt_n;
    end
  end

  always_comb begin
    stat_v = evt_q;
    stat_v[ST_EN]   = en_q;
    stat_v[ST_BUSY] = busy_i;
    stat_v[ST_WR]   = wr_i;
    stat_v[ST_CS_LSB +: 3] = cs_i;
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr)
      RA_CFG:   rdata_o[CFG_EDGE] = edge_q;
      RA_STAT:  rdata_o = stat_v;
      RA_IMASK: rdata_o = mask_q;
      RA_CYC0:  rdata_o = {24'h0, cyc0_q};
      default:  rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign cyc0_o = cyc0_q;
  assign irq_o  = |(evt_q & mask_q);

  assert_done_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> evt_q[ST_DONE]);
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (set_v == '0)) |=> (evt_q == '0));
  assert_no_mask_no_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int PULSE_CLKS  = 2,
  parameter int GAP_CLKS    = 2,
  parameter int NCS         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            cmd_wr,
  input  logic [26:2]     cmd_ofs,
  input  logic [31:0]     cmd_wdata,
  output logic [31:0]     cmd_rdata,
  output logic            irq,
  output logic            nand_cle,
  output logic            nand_ale,
  output logic            nand_we_n,
  output logic [NCS-1:0]  nand_ce_n,
  output logic [7:0]      nand_io,
  input  logic            nand_rb_n
);
  logic [1:0] rs_q;
  logic       rst_q_n;
  logic       en, busy, done, den, wr, rise, fall, go;
  logic [2:0] cs;
  logic [7:0] cyc0;
  cmd_t       cmd;

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  assign cmd = unpack_cmd({cmd_ofs, 2'b00});
  assign go  = cmd_wr & en & ~busy;

  nand_rb_watch #(.SYNC_STAGES(SYNC_STAGES)) i_rb (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .rb_n_i (nand_rb_n),
    .rise_o (rise),
    .fall_o (fall)
  );

  nand_pin_seq #(.PULSE_CLKS(PULSE_CLKS), .GAP_CLKS(GAP_CLKS), .NCS(NCS)) i_seq (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .go_i    (go),
    .cmd_i   (cmd),
    .abyte_i (cmd_wdata),
    .cyc0_i  (cyc0),
    .busy_o  (busy),
    .done_o  (done),
    .den_o   (den),
    .wr_o    (wr),
    .cs_o    (cs),
    .we_n_o  (nand_we_n),
    .cle_o   (nand_cle),
    .ale_o   (nand_ale),
    .ce_n_o  (nand_ce_n),
    .io_o    (nand_io)
  );

  nand_ctl_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy_i    (busy),
    .wr_i      (wr),
    .cs_i      (cs),
    .done_i    (done),
    .den_i     (den),
    .rise_i    (rise),
    .fall_i    (fall),
    .en_o      (en),
    .cyc0_o    (cyc0),
    .rdata_o   (reg_rdata),
    .irq_o     (irq)
  );

  always_comb begin
    cmd_rdata = '0;
    cmd_rdata[BUSY_BIT] = busy;
  end

  assert_ignore_disabled_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmd_wr && !en && !busy) |=> !busy);
  assert_issue_starts_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cmd_wr && en && !busy) |=> busy);

endmodule

// File: tb/test_nand_cmd_seq.sv
`timescale 1ns/1ps
module test_nand_cmd_seq;
  localparam int TB_PULSE = 3;
  localparam int TB_GAP   = 2;
  localparam int TB_NCS   = 8;
  localparam logic [31:0] EVT = 32'h0103_0030;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_wr = 1'b0;
  logic [26:2] cmd_ofs = '0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        irq, nand_cle, nand_ale, nand_we_n;
  logic [TB_NCS-1:0] nand_ce_n;
  logic [7:0]  nand_io;
  logic        nand_rb_n = 1'b1;

  int n_chk = 0, n_err = 0;
  bit fin = 1'b0;

  nand_cmd_seq #(.PULSE_CLKS(TB_PULSE), .GAP_CLKS(TB_GAP), .NCS(TB_NCS)) i_nand_cmd_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_wr(cmd_wr), .cmd_ofs(cmd_ofs),
    .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .irq(irq), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_ce_n(nand_ce_n), .nand_io(nand_io),
    .nand_rb_n(nand_rb_n)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- pin monitor ----------------
  logic [7:0] rec_b [0:15];
  bit         rec_c [0:15];
  bit         rec_a [0:15];
  logic [7:0] rec_ce [0:15];
  int  rec_n = 0;
  bit  prev_we = 1'b1;
  int  low_cnt = 0, high_cnt = 0;
  logic [7:0] lo_io, lo_ce;
  bit  lo_cle, lo_ale;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_we_n) begin
        if (prev_we) begin
          if (rec_n > 0) chk(high_cnt == TB_GAP, "R4 gap width", high_cnt, TB_GAP);
          low_cnt = 0;
        end
        low_cnt++;
        lo_io = nand_io; lo_cle = nand_cle; lo_ale = nand_ale; lo_ce = nand_ce_n;
      end else begin
        if (!prev_we) begin
          chk(low_cnt == TB_PULSE, "R4 pulse width", low_cnt, TB_PULSE);
          chk(nand_io == lo_io && nand_cle == lo_cle && nand_ale == lo_ale,
              "R4 bus hold at rise", {nand_cle, nand_ale, nand_io}, {lo_cle, lo_ale, lo_io});
          if (rec_n < 16) begin
            rec_b[rec_n] = lo_io; rec_c[rec_n] = lo_cle;
            rec_a[rec_n] = lo_ale; rec_ce[rec_n] = lo_ce;
          end
          rec_n++;
          high_cnt = 0;
        end
        high_cnt++;
      end
      prev_we = nand_we_n;
    end
  end

  // ---------------- expected sequence ----------------
  logic [7:0] exp_b [0:15];
  bit         exp_c [0:15];
  int         exp_n;

  function automatic logic [31:0] mkw(input logic [7:0] op1, input logic [7:0] op2, input bit v2,
                                      input logic [2:0] nad, input logic [2:0] cs,
                                      input bit den, input bit wr);
    return {5'b0, wr, den, cs, nad, v2, op2, op1, 2'b00};
  endfunction

  task automatic build_exp(input logic [31:0] w, input logic [31:0] d, input logic [7:0] c0);
    int nad = int'(w[21:19]);
    if (nad > 5) nad = 5;
    exp_n = 0;
    exp_b[exp_n] = w[9:2]; exp_c[exp_n] = 1'b1; exp_n++;
    if (nad == 5) begin
      exp_b[exp_n] = c0; exp_c[exp_n] = 1'b0; exp_n++;
      for (int i = 0; i < 4; i++) begin exp_b[exp_n] = d[i*8 +: 8]; exp_c[exp_n] = 1'b0; exp_n++; end
    end else begin
      for (int i = 0; i < nad; i++) begin exp_b[exp_n] = d[i*8 +: 8]; exp_c[exp_n] = 1'b0; exp_n++; end
    end
    if (w[18]) begin exp_b[exp_n] = w[17:10]; exp_c[exp_n] = 1'b1; exp_n++; end
  endtask

  task automatic check_seq(input logic [31:0] w);
    logic [7:0] ce_exp = ~(8'd1 << w[24:22]);
    chk(rec_n == exp_n, "R2 cycle count", rec_n, exp_n);
    for (int k = 0; k < exp_n && k < rec_n; k++) begin
      chk(rec_b[k] == exp_b[k], "R3 byte order", rec_b[k], exp_b[k]);
      chk(rec_c[k] == exp_c[k] && rec_a[k] == !exp_c[k], "R2 latch select",
          {rec_c[k], rec_a[k]}, {exp_c[k], !exp_c[k]});
      chk(rec_ce[k] == ce_exp, "R5 chip enable", rec_ce[k], ce_exp);
    end
  endtask

  // ---------------- bus tasks ----------------
  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] d, input bit run, input bit intrude);
    @(posedge clk); rec_n = 0;
    @(negedge clk); cmd_wr = 1'b1; cmd_ofs = w[26:2]; cmd_wdata = d;
    @(negedge clk); cmd_wr = 1'b0;
    if (run) begin
      chk(cmd_rdata[27] == 1'b1, "R1 busy readback", cmd_rdata, 32'h0800_0000);
      #1 chk(nand_ce_n == ~(8'd1 << w[24:22]), "R5 ce during busy", nand_ce_n, ~(8'd1 << w[24:22]));
    end else begin
      chk(cmd_rdata[27] == 1'b0, "R7 ignored while disabled", cmd_rdata, 0);
    end
    if (intrude) begin
      repeat (3) @(negedge clk);
      cmd_wr = 1'b1; cmd_ofs = ~w[26:2]; cmd_wdata = ~d;
      @(negedge clk); cmd_wr = 1'b0;
    end
    for (int i = 0; i < 400 && cmd_rdata[27]; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  logic [31:0] rd;

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_err++;
      $display("FAIL watchdog R1 run never ended act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int seed_v;
    logic [31:0] w, d;
    seed_v = $urandom(32'd31337);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk(nand_we_n == 1'b1 && nand_cle == 1'b0 && nand_ale == 1'b0, "R12 pin idle",
        {nand_we_n, nand_cle, nand_ale}, 3'b100);
    chk(nand_ce_n == '1 && nand_io == 8'h00 && irq == 1'b0, "R12 ce/io/irq",
        {nand_ce_n, nand_io, irq}, {8'hff, 8'h00, 1'b0});
    chk(cmd_rdata == 32'h0, "R12 busy readback", cmd_rdata, 0);
    rd_reg(3'd2, rd); chk(rd == 32'h0, "R12 status", rd, 0);
    rd_reg(3'd5, rd); chk(rd == 32'h0, "R12 mask", rd, 0);

    // R7 disabled: issue ignored
    w = mkw(8'h70, 8'h00, 1'b0, 3'd0, 3'd1, 1'b0, 1'b0);
    issue(w, 32'h0, 1'b0, 1'b0);
    chk(rec_n == 0, "R7 no pulses while disabled", rec_n, 0);

    wr_reg(3'd1, 32'h1);
    wr_reg(3'd6, 32'hA5);

    // directed: 5 addr cycles + second opcode (R2, R3, R5)
    w = mkw(8'h00, 8'h30, 1'b1, 3'd5, 3'd3, 1'b1, 1'b0);
    d = 32'h4433_2211;
    build_exp(w, d, 8'hA5);
    issue(w, d, 1'b1, 1'b0);
    check_seq(w);
    rd_reg(3'd2, rd);
    chk(rd == (32'h1 | (32'd3 << 12) | (32'd1 << 16) | (32'd1 << 17)), "R8 done+xfr status",
        rd, (32'h1 | (32'd3 << 12) | (32'd1 << 16) | (32'd1 << 17)));
    rd_reg(3'd2, rd);
    chk(rd == (32'h1 | (32'd3 << 12)), "R10 cleared by read", rd, (32'h1 | (32'd3 << 12)));

    // R6 intrusion while busy, R8 without data-enable, R1 wr flag
    w = mkw(8'h80, 8'h10, 1'b1, 3'd4, 3'd6, 1'b0, 1'b1);
    d = 32'hDEAD_BEEF;
    build_exp(w, d, 8'hA5);
    issue(w, d, 1'b1, 1'b1);
    check_seq(w);
    rd_reg(3'd2, rd);
    chk((rd & EVT) == (32'd1 << 17), "R8 done only", rd & EVT, 32'd1 << 17);
    chk(rd[14:12] == 3'd6 && rd[11] == 1'b1, "R1 latched cs/wr", rd[14:11], {3'd6, 1'b1});

    // R3 count 6 acts as 5, count 0 without second opcode
    w = mkw(8'h05, 8'hE0, 1'b1, 3'd6, 3'd0, 1'b0, 1'b0);
    d = 32'h0102_0304;
    build_exp(w, d, 8'hA5);
    issue(w, d, 1'b1, 1'b0);
    check_seq(w);
    w = mkw(8'hFF, 8'h00, 1'b0, 3'd0, 3'd7, 1'b0, 1'b0);
    build_exp(w, 32'h0, 8'hA5);
    issue(w, 32'h0, 1'b1, 1'b0);
    check_seq(w);

    // R11 interrupt mask
    chk(irq == 1'b0, "R11 unmasked event no irq", irq, 0);
    wr_reg(3'd3, 32'd1 << 17);
    chk(irq == 1'b1, "R11 irq on enable", irq, 1);
    rd_reg(3'd5, rd); chk(rd == (32'd1 << 17), "R11 mask readback", rd, 32'd1 << 17);
    wr_reg(3'd4, 32'd1 << 17);
    chk(irq == 1'b0, "R11 irq off after clear", irq, 0);
    wr_reg(3'd3, 32'd1 << 17);
    rd_reg(3'd2, rd);
    @(negedge clk);
    chk(irq == 1'b0, "R10 irq gone after read", irq, 0);
    wr_reg(3'd4, 32'hFFFF_FFFF);

    // R9 ready/busy edges, rising polarity
    wr_reg(3'd0, 32'h0);
    @(negedge clk); nand_rb_n = 1'b0;
    repeat (6) @(negedge clk);
    rd_reg(3'd2, rd);
    chk((rd & EVT) == (32'd1 << 5), "R9 fall with rising select", rd & EVT, 32'd1 << 5);
    @(negedge clk); nand_rb_n = 1'b1;
    repeat (6) @(negedge clk);
    rd_reg(3'd2, rd);
    chk((rd & EVT) == ((32'd1 << 4) | (32'd1 << 24)), "R9 rise sets edge", rd & EVT,
        (32'd1 << 4) | (32'd1 << 24));
    // falling polarity
    wr_reg(3'd0, 32'd1 << 12);
    rd_reg(3'd0, rd); chk(rd == (32'd1 << 12), "R9 config readback", rd, 32'd1 << 12);
    @(negedge clk); nand_rb_n = 1'b0;
    repeat (6) @(negedge clk);
    rd_reg(3'd2, rd);
    chk((rd & EVT) == ((32'd1 << 5) | (32'd1 << 24)), "R9 fall sets edge", rd & EVT,
        (32'd1 << 5) | (32'd1 << 24));
    @(negedge clk); nand_rb_n = 1'b1;
    repeat (6) @(negedge clk);
    rd_reg(3'd2, rd);
    chk((rd & EVT) == (32'd1 << 4), "R9 rise with falling select", rd & EVT, 32'd1 << 4);

    // random commands
    for (int it = 0; it < 24; it++) begin
      logic [7:0] c0;
      c0 = 8'($urandom);
      wr_reg(3'd6, {24'h0, c0});
      w = mkw(8'($urandom), 8'($urandom), 1'($urandom), 3'($urandom), 3'($urandom),
              1'($urandom), 1'($urandom));
      d = $urandom;
      build_exp(w, d, c0);
      issue(w, d, 1'b1, (it % 3) == 0);
      check_seq(w);
      rd_reg(3'd2, rd);
      chk(rd[17] == 1'b1 && rd[16] == w[25], "R8 random done/xfr", rd[17:16], {1'b1, w[25]});
    end

    // R7 disable wins, then issue ignored
    wr_reg(3'd1, 32'h3);
    w = mkw(8'h90, 8'h00, 1'b0, 3'd1, 3'd2, 1'b0, 1'b0);
    issue(w, 32'h55, 1'b0, 1'b0);
    chk(rec_n == 0, "R7 no pulses after disable", rec_n, 0);
    rd_reg(3'd2, rd);
    chk(rd[0] == 1'b0 && (rd & EVT) == 32'h0, "R7 disabled status", rd, 32'h0);

    fin = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule